// File: doc/BRIEF.md
# Asymmetric Dual-Clock RAM

A simple dual-port memory whose write port and read port run on separate, unrelated clocks and carry different data widths. The write side stores whole wide words of `WORD_W` bits. The read side uses a finer address and returns one narrow lane of `WORD_W/LANES` bits per access.

Each read fetches a full wide word and then picks one lane with the low bits of the read address. Because of this, the storage stays a uniform array of wide words that synthesis can map onto block memory. The read result is registered on the read clock. The lane-select bits are registered in the same stage as the word, so the multiplexer always pairs the data with its own address.

There is no handshake between the two clock domains. If a read and a write reach the same word close together in time, the read value is undefined.

Top module: `asym_dc_ram`

## Requirements
- R1: On a rising `wr_clk` edge with `wr_en` high, all 64 bits of `wr_data` are stored at wide word `wr_addr` (7 bits, 128 words).
- R2: On a rising `wr_clk` edge with `wr_en` low, no stored word changes.
- R3: The read address is 9 bits. Bits 8:2 select the wide word and bits 1:0 select the lane. Lane k returns stored bits [16k+15:16k], so lane 0 is bits 15:0.
- R4: `rd_data` shows the lane addressed at a rising `rd_clk` edge from that edge onward. It holds that value until the next rising `rd_clk` edge, even if `rd_addr` changes in between.
- R5: At a rising `rd_clk` edge with `rd_rst_n` low, the read output register clears, so `rd_data` is zero.
- R6: Writes on `wr_clk` and reads on `rd_clk` run concurrently without affecting each other, provided they touch different wide words.
- R7: Every narrow address is reachable, including narrow address 0, narrow address 511, and all four lanes of a single word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write strobe for the wide word |
| wr_addr | input | 7 | Wide word address |
| wr_data | input | 64 | Wide word to store |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Active-low synchronous clear of the read register |
| rd_addr | input | 9 | Narrow read address: word in the upper bits, lane in bits 1:0 |
| rd_data | output | 16 | Registered narrow read result |

## Verification
The bench builds the block with its default parameters: 64-bit words, four lanes and 128 words. At that size, filling every word and then reading random narrow addresses reaches every lane position and both ends of the address range within a short run. The two clocks are set at unrelated periods, and a concurrent phase writes the upper half of the memory while reading the lower half. Directed cases cover a suppressed write, the read latency, and the hold of `rd_data` while the address changes between read edges.

// File: rtl/asym_dc_ram.sv
module asym_dc_ram #(
  parameter int WORD_W  = 64,
  parameter int LANES   = 4,
  parameter int WADDR_W = 7,
  localparam int LANE_W  = WORD_W / LANES,
  localparam int SEL_W   = $clog2(LANES),
  localparam int RADDR_W = WADDR_W + SEL_W,
  localparam int DEPTH   = 1 << WADDR_W
) (
  input  logic               wr_clk,
  input  logic               wr_en,
  input  logic [WADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               rd_clk,
  input  logic               rd_rst_n,
  input  logic [RADDR_W-1:0] rd_addr,
  output logic [LANE_W-1:0]  rd_data
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] word_q;
  logic [SEL_W-1:0]  lane_q;
  logic [LANE_W-1:0] lane_v [LANES];

  always_ff @(posedge wr_clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  always_ff @(posedge rd_clk)
    if (!rd_rst_n) begin
      word_q <= '0;
      lane_q <= '0;
    end else begin
      word_q <= mem[rd_addr[RADDR_W-1:SEL_W]];
      lane_q <= rd_addr[SEL_W-1:0];
    end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_v[g] = word_q[g*LANE_W +: LANE_W];
  end

  assign rd_data = lane_v[lane_q];

endmodule

// File: rtl/asym_dc_ram_chk.sv
module asym_dc_ram_chk #(
  parameter int WORD_W  = 64,
  parameter int LANES   = 4,
  parameter int WADDR_W = 7,
  localparam int LANE_W  = WORD_W / LANES,
  localparam int SEL_W   = $clog2(LANES),
  localparam int RADDR_W = WADDR_W + SEL_W,
  localparam int DEPTH   = 1 << WADDR_W
) (
  input logic               wr_clk,
  input logic               wr_en,
  input logic [WADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0]  wr_data,
  input logic               rd_clk,
  input logic               rd_rst_n,
  input logic [RADDR_W-1:0] rd_addr,
  input logic [LANE_W-1:0]  rd_data,
  input logic [WORD_W-1:0]  mem [DEPTH]
);

  logic [LANE_W-1:0] exp_slice;
  logic [WORD_W-1:0] cur_word;
  logic              rst_q;

  always_comb begin
    cur_word  = mem[rd_addr[RADDR_W-1:SEL_W]];
    exp_slice = cur_word[rd_addr[SEL_W-1:0]*LANE_W +: LANE_W];
  end

  always_ff @(posedge rd_clk) rst_q <= !rd_rst_n;

  always @(negedge rd_clk)
    if (rst_q) AST_RST_CLEAR: assert (rd_data == '0) else $error("read reg not cleared"); // R5

  AST_LANE_PICK: assert property (@(posedge rd_clk) disable iff (!rd_rst_n) 1'b1 |=> rd_data == $past(exp_slice)); // R3
  AST_WRITE_LANDS: assert property (@(posedge wr_clk) disable iff (!rd_rst_n) wr_en |=> mem[$past(wr_addr)] == $past(wr_data)); // R1
  AST_HOLD_NO_WE: assert property (@(posedge wr_clk) disable iff (!rd_rst_n) !wr_en |=> mem[$past(wr_addr)] == $past(mem[wr_addr])); // R2

endmodule

bind asym_dc_ram asym_dc_ram_chk #(.WORD_W(WORD_W), .LANES(LANES), .WADDR_W(WADDR_W)) u_chk (
  .wr_clk(wr_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
  .mem(mem)
);

// File: tb/asym_dc_ram_bench.sv
module asym_dc_ram_bench;
  localparam int WORD_W = 64, LANES = 4, WADDR_W = 7;
  localparam int LANE_W = WORD_W / LANES, RADDR_W = WADDR_W + 2, DEPTH = 1 << WADDR_W;

  logic wr_clk = 0, rd_clk = 0, wr_en = 0, rd_rst_n = 0;
  logic [WADDR_W-1:0] wr_addr = '0;
  logic [WORD_W-1:0]  wr_data = '0;
  logic [RADDR_W-1:0] rd_addr = '0;
  logic [LANE_W-1:0]  rd_data;
  logic [WORD_W-1:0]  model [DEPTH];
  int total = 0, bad = 0;

  always #2 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  asym_dc_ram u_asym_dc_ram (.wr_clk(wr_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic logic [LANE_W-1:0] exp_lane(input logic [RADDR_W-1:0] a);
    logic [WORD_W-1:0] w = model[a[RADDR_W-1:2]];
    return w[a[1:0]*LANE_W +: LANE_W];
  endfunction

  task automatic check(input string tag, input logic [LANE_W-1:0] act, input logic [LANE_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [WADDR_W-1:0] a, input logic [WORD_W-1:0] d, input logic en);
    @(negedge wr_clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge wr_clk);
    wr_en = 0;
    if (en) model[a] = d;
  endtask

  task automatic rd(input logic [RADDR_W-1:0] a, input string tag);
    @(negedge rd_clk);
    rd_addr = a;
    @(negedge rd_clk);
    check(tag, rd_data, exp_lane(a));
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R5: reset clears the read register
    repeat (3) @(negedge rd_clk);
    check("R5 reset", rd_data, '0);
    rd_rst_n = 1;
    // R1: fill every word
    for (int i = 0; i < DEPTH; i++) wr(i[WADDR_W-1:0], {$urandom, $urandom}, 1'b1);
    // R7: boundaries and all lanes of one word
    rd('0, "R7 addr 0");
    rd('1, "R7 addr 511");
    for (int l = 0; l < 4; l++) rd({7'd5, l[1:0]}, "R7 lanes of word 5");
    // R3: known pattern, lane k holds k+1 in each nibble
    wr(7'd20, 64'h4444_3333_2222_1111, 1'b1);
    for (int l = 0; l < 4; l++) begin
      @(negedge rd_clk); rd_addr = {7'd20, l[1:0]};
      @(negedge rd_clk);
      check("R3 lane mapping", rd_data, {4{4'(l + 1)}});
    end
    // R2: suppressed write leaves word intact
    wr(7'd9, 64'hdead_beef_dead_beef, 1'b0);
    for (int l = 0; l < 4; l++) rd({7'd9, l[1:0]}, "R2 no write");
    // R4: value held between edges while address changes
    @(negedge rd_clk); rd_addr = {7'd20, 2'd2};
    @(negedge rd_clk); rd_addr = {7'd20, 2'd0};
    #1 check("R4 hold", rd_data, 16'h3333);
    @(negedge rd_clk);
    check("R4 latency", rd_data, 16'h1111);
    // R1/R3: random reads
    for (int i = 0; i < 300; i++) rd(RADDR_W'($urandom), "R1 random read");
    // R6: concurrent writes to upper half, reads from lower half
    fork
      for (int i = 64; i < 128; i++) wr(i[WADDR_W-1:0], {$urandom, $urandom}, 1'b1);
      for (int i = 0; i < 150; i++) rd({1'b0, 8'($urandom)}, "R6 concurrent");
    join
    for (int i = 0; i < 100; i++) rd({1'b1, 8'($urandom)}, "R6 after concurrent");
    // R5: reset again mid-run
    @(negedge rd_clk); rd_rst_n = 0;
    @(negedge rd_clk);
    check("R5 reset again", rd_data, '0);
    rd_rst_n = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule